// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte-wide exchange point between a host CPU bus and an embedded keyboard-controller core. The host owns one direction and the core owns the other. Each direction has a single-byte slot and a handshake flag. An address bit on the host side chooses between the data port and the command/status port.

A host write to either address fills the inbound slot and raises the inbound-full flag. It also records in a command/data flag which address was used. The core reads the inbound slot to take the byte, and that clears inbound-full. The core's interrupt line follows inbound-full. In the other direction, a core write fills the outbound slot and raises outbound-full. A host read of the data address takes the byte and clears the flag. A host interrupt request is raised while outbound-full is set, but only if the core enables it.

The status byte packs the flags at fixed bit positions. The core can write the remaining status bits freely. Reset is asserted asynchronously and released in step with the clock.

Top module: `kbm_mailbox`

## Requirements
- R1: After reset, both slots read zero, the status byte is zero, and kirq and ibf_irq are low.
- R2: A host write (host_wr) stores host_wdata in the inbound slot and sets IBF (status bit 1) on the next cycle. It sets the C/D flag (status bit 3) to host_a0, so address 1 means command and address 0 means data.
- R3: core_rdata always shows the inbound slot. A core_rd_data strobe clears IBF unless a host write happens in the same cycle, in which case IBF stays set.
- R4: A core_wr_data strobe stores core_wdata in the outbound slot and sets OBF (status bit 0) on the next cycle.
- R5: With host_a0 = 0, host_rdata shows the outbound slot. A host_rd strobe at that address clears OBF unless a core data write happens in the same cycle.
- R6: kirq is high exactly when OBF is set and kirq_en is high. ibf_irq is high exactly when IBF is set.
- R7: With host_a0 = 1, host_rdata shows the status byte. Reading it changes no state.
- R8: A core_wr_status strobe loads status bits 2, 4, 5, 6 and 7 from core_wdata. Bits 0, 1 and 3 keep their flag values. Without the strobe, the user bits hold.
- R9: A host write while IBF is already set replaces the stored byte, and IBF stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_a0 | input | 1 | Host address: 0 data, 1 command/status |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte (outbound slot or status) |
| core_wr_data | input | 1 | Core write strobe, outbound slot |
| core_wr_status | input | 1 | Core write strobe, user status bits |
| core_rd_data | input | 1 | Core read strobe, inbound slot |
| core_wdata | input | DATA_W | Core write byte |
| core_rdata | output | DATA_W | Inbound slot contents |
| core_status | output | DATA_W | Status byte as seen by the core |
| kirq_en | input | 1 | Enable for the host interrupt request |
| kirq | output | 1 | Host interrupt request (level) |
| ibf_irq | output | 1 | Core interrupt: a host byte is waiting |

## Verification
The bench builds the block with the default DATA_W of 8. This is the width at which the flag positions and the user-bit mask match the status layout the host expects. At that width, random traffic often puts host and core strobes in the same cycle. That exercises the same-cycle write-wins cases and overwrites while a slot is full, together with toggling of the interrupt enable.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
  localparam int unsigned ST_OBF = 0;
  localparam int unsigned ST_IBF = 1;
  localparam int unsigned ST_CD  = 3;

  function automatic logic is_flag_bit(input int unsigned b);
    return (b == ST_OBF) || (b == ST_IBF) || (b == ST_CD);
  endfunction
endpackage

// File: rtl/kbm_in_slot.sv
module kbm_in_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwr,
  input  logic              hcmd,
  input  logic [DATA_W-1:0] hdata,
  input  logic              crd,
  output logic [DATA_W-1:0] slot,
  output logic              full,
  output logic              cmd
);
  logic [DATA_W-1:0] slot_d;
  logic              full_d;
  logic              cmd_d;

  always_comb begin
    slot_d = slot;
    cmd_d  = cmd;
    full_d = full;
    if (crd) full_d = 1'b0;
    if (hwr) begin
      slot_d = hdata;
      cmd_d  = hcmd;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      full <= 1'b0;
      cmd  <= 1'b0;
    end else begin
      slot <= slot_d;
      full <= full_d;
      cmd  <= cmd_d;
    end
  end

  p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hwr |=> full);
  p_cd_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hwr |=> (cmd == $past(hcmd)));
  p_ibf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (crd && !hwr) |=> !full);
  p_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hwr |=> (slot == $past(hdata)));
endmodule

// File: rtl/kbm_out_slot.sv
module kbm_out_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cwr,
  input  logic [DATA_W-1:0] cdata,
  input  logic              hrd,
  output logic [DATA_W-1:0] slot,
  output logic              full
);
  logic [DATA_W-1:0] slot_d;
  logic              full_d;

  always_comb begin
    slot_d = slot;
    full_d = full;
    if (hrd) full_d = 1'b0;
    if (cwr) begin
      slot_d = cdata;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      full <= 1'b0;
    end else begin
      slot <= slot_d;
      full <= full_d;
    end
  end

  p_obf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> (full && slot == $past(cdata)));
  p_obf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hrd && !cwr) |=> !full);
endmodule

// File: rtl/kbm_user_bits.sv
module kbm_user_bits #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bits
);
  import kbm_pkg::*;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] bits_d;

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign mask[b] = !is_flag_bit(b);
  end

  always_comb begin
    bits_d = bits;
    if (we) bits_d = wdata & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= bits_d;
  end

  p_user_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bits));
  p_user_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bits[ST_OBF] == 1'b0) && (bits[ST_IBF] == 1'b0) && (bits[ST_CD] == 1'b0));
endmodule

// File: rtl/kbm_mailbox.sv
module kbm_mailbox #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_a0,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              core_wr_data,
  input  logic              core_wr_status,
  input  logic              core_rd_data,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] core_status,
  input  logic              kirq_en,
  output logic              kirq,
  output logic              ibf_irq
);
  import kbm_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [DATA_W-1:0] in_slot;
  logic [DATA_W-1:0] out_slot;
  logic [DATA_W-1:0] user_bits;
  logic [DATA_W-1:0] status;
  logic              ibf;
  logic              obf;
  logic              cd;
  logic              host_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign host_rd_data = host_rd && !host_a0;

  kbm_in_slot #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_int_n), .hwr(host_wr), .hcmd(host_a0),
    .hdata(host_wdata), .crd(core_rd_data), .slot(in_slot),
    .full(ibf), .cmd(cd)
  );

  kbm_out_slot #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_int_n), .cwr(core_wr_data), .cdata(core_wdata),
    .hrd(host_rd_data), .slot(out_slot), .full(obf)
  );

  kbm_user_bits #(.DATA_W(DATA_W)) u_user (
    .clk(clk), .rst_n(rst_int_n), .we(core_wr_status), .wdata(core_wdata),
    .bits(user_bits)
  );

  always_comb begin
    status         = user_bits;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_CD]  = cd;
  end

  assign host_rdata  = host_a0 ? status : out_slot;
  assign core_rdata  = in_slot;
  assign core_status = status;
  assign kirq        = obf && kirq_en;
  assign ibf_irq     = ibf;

  p_kirq_needs_obf_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    kirq |-> host_rd || core_status[ST_OBF]);
  p_kirq_gate_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !kirq_en |-> !kirq);
  p_status_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_rd && host_a0 && !host_wr && !core_wr_data && !core_wr_status && !core_rd_data)
      |=> $stable(core_status) && $stable(out_slot) && $stable(in_slot));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!kirq && !ibf_irq));
endmodule

// File: tb/kbm_mailbox_tb.sv
module kbm_mailbox_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] UMASK = 8'hF4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_a0 = 0;
  logic [W-1:0] host_wdata = '0, core_wdata = '0;
  logic core_wr_data = 0, core_wr_status = 0, core_rd_data = 0, kirq_en = 0;
  logic [W-1:0] host_rdata, core_rdata, core_status;
  logic kirq, ibf_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_in, m_out, m_user;
  logic m_ibf, m_obf, m_cd;

  always #4 clk = ~clk;

  kbm_mailbox #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_a0(host_a0), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_wr_data(core_wr_data), .core_wr_status(core_wr_status),
    .core_rd_data(core_rd_data), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_status(core_status),
    .kirq_en(kirq_en), .kirq(kirq), .ibf_irq(ibf_irq)
  );

  function automatic logic [W-1:0] exp_status();
    logic [W-1:0] s;
    s = m_user & UMASK;
    s[0] = m_obf;
    s[1] = m_ibf;
    s[3] = m_cd;
    return s;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_all();
    chk("R3 core_rdata", core_rdata, m_in);
    chk("R2 R8 status", core_status, exp_status());
    chk(host_a0 ? "R7 host_rdata status" : "R5 host_rdata data",
        host_rdata, host_a0 ? exp_status() : m_out);
    chk("R6 kirq", {7'd0, kirq}, {7'd0, m_obf & kirq_en});
    chk("R6 ibf_irq", {7'd0, ibf_irq}, {7'd0, m_ibf});
  endtask

  task automatic step(input logic hw, input logic hr, input logic a0,
                      input logic [W-1:0] hd, input logic cwd, input logic cws,
                      input logic crd, input logic [W-1:0] cd, input logic en);
    host_wr = hw; host_rd = hr; host_a0 = a0; host_wdata = hd;
    core_wr_data = cwd; core_wr_status = cws; core_rd_data = crd;
    core_wdata = cd; kirq_en = en;
    #1;
    check_all();
    @(posedge clk);
    if (crd) m_ibf = 1'b0;
    if (hw) begin m_in = hd; m_ibf = 1'b1; m_cd = a0; end
    if (hr && !a0) m_obf = 1'b0;
    if (cwd) begin m_out = cd; m_obf = 1'b1; end
    if (cws) m_user = cd & UMASK;
    @(negedge clk);
    host_wr = 0; host_rd = 0; core_wr_data = 0; core_wr_status = 0; core_rd_data = 0;
    #1;
    check_all();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    m_in = '0; m_out = '0; m_user = '0; m_ibf = 0; m_obf = 0; m_cd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 status", core_status, 8'h00);
    chk("R1 core_rdata", core_rdata, 8'h00);
    chk("R1 host_rdata", host_rdata, 8'h00);
    chk("R1 irqs", {6'd0, kirq, ibf_irq}, 8'h00);
    // R2 data write, then command write with R9 overwrite
    step(1, 0, 0, 8'h5A, 0, 0, 0, 8'h00, 1);
    chk("R2 cd data", {7'd0, core_status[3]}, 8'h00);
    step(1, 0, 1, 8'hC3, 0, 0, 0, 8'h00, 1);
    chk("R9 overwrite", core_rdata, 8'hC3);
    chk("R2 cd cmd", {7'd0, core_status[3]}, 8'h01);
    // R3 core read clears IBF
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'h00, 1);
    chk("R3 ibf cleared", {7'd0, ibf_irq}, 8'h00);
    // R3 same-cycle host write and core read keeps IBF
    step(1, 0, 0, 8'h11, 0, 0, 1, 8'h00, 1);
    chk("R3 collision ibf", {7'd0, core_status[1]}, 8'h01);
    // R4/R6 core write, kirq enabled then disabled
    step(0, 0, 0, 8'h00, 1, 0, 0, 8'hA7, 1);
    chk("R6 kirq on", {7'd0, kirq}, 8'h01);
    step(0, 0, 1, 8'h00, 0, 0, 0, 8'h00, 0);
    chk("R6 kirq masked", {7'd0, kirq}, 8'h00);
    // R7 status read has no effect
    step(0, 1, 1, 8'h00, 0, 0, 0, 8'h00, 1);
    chk("R7 obf kept", {7'd0, core_status[0]}, 8'h01);
    // R5 host data read clears OBF; collision keeps it
    step(0, 1, 0, 8'h00, 1, 0, 0, 8'h3C, 1);
    chk("R5 collision obf", {7'd0, core_status[0]}, 8'h01);
    step(0, 1, 0, 8'h00, 0, 0, 0, 8'h00, 1);
    chk("R5 obf cleared", {7'd0, kirq}, 8'h00);
    // R8 user bits written, flags preserved
    step(0, 0, 0, 8'h00, 0, 1, 0, 8'hFF, 1);
    chk("R8 user bits", core_status & UMASK, 8'hF4);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[0], r[1], r[2], r[15:8], r[3] & r[4], r[5] & r[6], r[7],
           r[23:16], r[24] | r[25]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule